// File: doc/BRIEF.md
# Virtual Coset Write Encoder

This block prepares one 64-bit word, already encrypted and so statistically random, for storage in a memory whose cells wear out with each change of state. Alongside the new word it takes the word currently held at the target address and four 16-bit kernel strings. It returns an encoded word that changes as few stored cells as it can, together with a 6-bit auxiliary index that a reader needs to undo the encoding.

The word is cut into four 16-bit slices. Every kernel is applied to every slice in parallel, both plainly (XOR) and inverted (XNOR). For each kernel, every slice independently keeps whichever of the two forms disturbs fewer stored bits. The per-slice results add up to a total cost for that kernel, and the kernel with the cheapest total wins. Four kernels with sixteen inversion patterns each give 64 candidate cosets, yet only four short strings need to be held anywhere. The ones in the auxiliary index are charged as part of the cost.

A single-cycle strobe loads the inputs. The encoded word and its index are registered and appear with a one-cycle valid pulse.

Top module: `vcc_encoder`

## Requirements
- R1: Inputs are loaded at a rising edge where `inValid` is high. `codeWord` and `auxIndex` hold the result after the following rising edge, and `outValid` is high for exactly that one cycle.
- R2: While reset is asserted and until the first result, `outValid`, `codeWord` and `auxIndex` are all zero.
- R3: Slice p is bits [16p+15:16p] of a word. Kernel k is `kernels[16k+15:16k]`. Slice p of `codeWord` equals slice p of `newData` XOR the chosen kernel, bitwise inverted when flag p is set.
- R4: `auxIndex[5:4]` holds the chosen kernel number. `auxIndex[p]` (p = 0..3) is 1 when slice p used the inverted form.
- R5: Within the chosen kernel, a slice's flag is set exactly when its plain form differs from the stored slice in more than 8 bit positions. A difference of exactly 8 leaves the flag clear. So each slice of `codeWord` differs from the stored slice in at most 8 positions, and in at most 7 when its flag is set.
- R6: The cost of a candidate is the number of bits in which it differs from `oldData`, plus the number of ones in its 6-bit index. The result is a candidate of minimum cost among all 64.
- R7: When several kernels reach the same minimum cost, the lowest kernel number is chosen.
- R8: Applying the chosen kernel (inverted where flagged) to each slice of `codeWord` gives back `newData`.
- R9: Strobes on consecutive cycles each give their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Load strobe for the three data inputs |
| newData | input | 64 | Encrypted word to be written |
| oldData | input | 64 | Word presently stored at the address |
| kernels | input | 64 | Four 16-bit kernels, kernel k in bits [16k+15:16k] |
| outValid | output | 1 | One-cycle pulse marking a fresh result |
| codeWord | output | 64 | Encoded word to store |
| auxIndex | output | 6 | Kernel number [5:4] and slice inversion flags [3:0] |

## Verification
Every result is due two rising edges after the edge that samples its strobe: one edge loads the inputs and the next registers the outputs. The bench drives inputs on falling edges. It reads the outputs on the falling edge that follows that second rising edge, and again one cycle later to confirm the pulse has ended. For back-to-back strobes, it reads on two consecutive falling edges. Expected values come from a plain search over all 64 indices that charges each candidate its changed bits plus its index ones and keeps the first strict minimum. Directed words cover the exact-half slice, fully inverted slices and equal kernels.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  parameter int DATA_W   = 64;
  parameter int PART_W   = 16;
  parameter int NUM_KERN = 4;

  localparam int NUM_PART = DATA_W / PART_W;
  localparam int KIDX_W   = $clog2(NUM_KERN);
  localparam int AUX_W    = KIDX_W + NUM_PART;
  localparam int KBUS_W   = NUM_KERN * PART_W;
  localparam int CNT_W    = $clog2(DATA_W + AUX_W + 1);

  typedef struct packed {
    logic capture;
    logic publish;
  } ctrl_t;
endpackage

// File: rtl/vcc_ctrl.sv
module vcc_ctrl
  import vcc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output ctrl_t ctrl
);
  logic pendQ;

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= inValid;
  end

  always_comb begin
    ctrl.capture = inValid & rstN;
    ctrl.publish = pendQ;
  end
endmodule

// File: rtl/vcc_part_eval.sv
module vcc_part_eval
  import vcc_pkg::*;
#(
  parameter int W = PART_W
) (
  input  logic [W-1:0]     dataSub,
  input  logic [W-1:0]     oldSub,
  input  logic [W-1:0]     kern,
  output logic [W-1:0]     encSub,
  output logic             invFlag,
  output logic [CNT_W-1:0] cost
);
  logic [W-1:0]     plainSub;
  logic [CNT_W-1:0] diffCnt;

  always_comb begin
    plainSub = dataSub ^ kern;
    diffCnt  = CNT_W'($countones(plainSub ^ oldSub));
    invFlag  = diffCnt > CNT_W'(W / 2);
    encSub   = invFlag ? ~plainSub : plainSub;
    // an inverted slice also pays for its flag bit
    cost     = invFlag ? (CNT_W'(W) - diffCnt + CNT_W'(1)) : diffCnt;
  end
endmodule

// File: rtl/vcc_datapath.sv
module vcc_datapath
  import vcc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] newData,
  input  logic [DATA_W-1:0] oldData,
  input  logic [KBUS_W-1:0] kernels,
  output logic              outValid,
  output logic [DATA_W-1:0] codeWord,
  output logic [AUX_W-1:0]  auxIndex
);
  logic [DATA_W-1:0] dataQ, oldQ;
  logic [KBUS_W-1:0] kernQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      oldQ  <= '0;
      kernQ <= '0;
    end else if (ctrl.capture) begin
      dataQ <= newData;
      oldQ  <= oldData;
      kernQ <= kernels;
    end
  end

  logic [NUM_KERN-1:0][DATA_W-1:0]   candWord;
  logic [NUM_KERN-1:0][NUM_PART-1:0] candFlags;
  logic [CNT_W-1:0] partCost [NUM_KERN][NUM_PART];

  for (genvar k = 0; k < NUM_KERN; k++) begin : g_kern
    for (genvar p = 0; p < NUM_PART; p++) begin : g_part
      vcc_part_eval #(.W(PART_W)) eval_i (
        .dataSub (dataQ[p*PART_W +: PART_W]),
        .oldSub  (oldQ[p*PART_W +: PART_W]),
        .kern    (kernQ[k*PART_W +: PART_W]),
        .encSub  (candWord[k][p*PART_W +: PART_W]),
        .invFlag (candFlags[k][p]),
        .cost    (partCost[k][p])
      );
    end
  end

  logic [CNT_W-1:0]  kernTotal [NUM_KERN];
  logic [KIDX_W-1:0] bestIdx;
  logic [CNT_W-1:0]  bestCost;

  always_comb begin
    for (int k = 0; k < NUM_KERN; k++) begin
      kernTotal[k] = CNT_W'($countones(KIDX_W'(k)));
      for (int p = 0; p < NUM_PART; p++)
        kernTotal[k] = kernTotal[k] + partCost[k][p];
    end
    bestIdx  = '0;
    bestCost = kernTotal[0];
    for (int k = 1; k < NUM_KERN; k++) begin
      if (kernTotal[k] < bestCost) begin
        bestCost = kernTotal[k];
        bestIdx  = KIDX_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      codeWord <= '0;
      auxIndex <= '0;
    end else begin
      outValid <= ctrl.publish;
      if (ctrl.publish) begin
        codeWord <= candWord[bestIdx];
        auxIndex <= {bestIdx, candFlags[bestIdx]};
      end
    end
  end
endmodule

// File: rtl/vcc_encoder.sv
module vcc_encoder
  import vcc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] newData,
  input  logic [DATA_W-1:0] oldData,
  input  logic [KBUS_W-1:0] kernels,
  output logic              outValid,
  output logic [DATA_W-1:0] codeWord,
  output logic [AUX_W-1:0]  auxIndex
);
  ctrl_t ctrl;

  vcc_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ctrl    (ctrl)
  );

  vcc_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .newData  (newData),
    .oldData  (oldData),
    .kernels  (kernels),
    .outValid (outValid),
    .codeWord (codeWord),
    .auxIndex (auxIndex)
  );
endmodule

// File: rtl/vcc_encoder_chk.sv
module vcc_encoder_chk
  import vcc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] newData,
  input logic [DATA_W-1:0] oldData,
  input logic [KBUS_W-1:0] kernels,
  input logic              outValid,
  input logic [DATA_W-1:0] codeWord,
  input logic [AUX_W-1:0]  auxIndex
);
  logic [DATA_W-1:0] dataP1, dataP2, oldP1, oldP2;
  logic [KBUS_W-1:0] kernP1, kernP2;

  always_ff @(posedge clk) begin
    dataP1 <= newData;  dataP2 <= dataP1;
    oldP1  <= oldData;  oldP2  <= oldP1;
    kernP1 <= kernels;  kernP2 <= kernP1;
  end

  logic [DATA_W-1:0] decoded;
  logic              sliceOk;

  always_comb begin
    decoded = '0;
    sliceOk = 1'b1;
    for (int p = 0; p < NUM_PART; p++) begin
      logic [PART_W-1:0] kSel;
      int dc;
      kSel = kernP2[int'(auxIndex[AUX_W-1:NUM_PART])*PART_W +: PART_W];
      if (auxIndex[p]) kSel = ~kSel;
      decoded[p*PART_W +: PART_W] = codeWord[p*PART_W +: PART_W] ^ kSel;
      dc = $countones(codeWord[p*PART_W +: PART_W] ^ oldP2[p*PART_W +: PART_W]);
      if (auxIndex[p] ? (dc >= PART_W/2) : (dc > PART_W/2)) sliceOk = 1'b0;
    end
  end

  // R1: a strobe yields a result two edges later
  a_r1_result_due: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  // R1: no result without a strobe
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R8: the stored word decodes to the loaded data
  a_r8_decodes: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> decoded == dataP2);

  // R5: slice distance bounds follow the flag rule
  a_r5_flag_rule: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> sliceOk);

  // R2: outputs hold while no result is signalled
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |=> $stable(codeWord) && $stable(auxIndex));
endmodule

bind vcc_encoder vcc_encoder_chk chk_i (.*);

// File: tb/vcc_encoder_tb_top.sv
module vcc_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] newData = '0, oldData = '0, kernels = '0;
  logic        outValid;
  logic [63:0] codeWord;
  logic [5:0]  auxIndex;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  vcc_encoder dut_i (.*);

  function automatic logic [63:0] build(input logic [63:0] d, input logic [63:0] kb,
                                        input int idx);
    logic [63:0] w;
    for (int p = 0; p < 4; p++) begin
      logic [15:0] ks;
      ks = kb[(idx >> 4)*16 +: 16];
      if (idx[p]) ks = ~ks;
      w[p*16 +: 16] = d[p*16 +: 16] ^ ks;
    end
    return w;
  endfunction

  // exhaustive search: changed bits plus index ones, first strict minimum
  function automatic int bestIndex(input logic [63:0] d, input logic [63:0] o,
                                   input logic [63:0] kb);
    int best = 0, bestCost = 1000;
    for (int i = 0; i < 64; i++) begin
      int c = $countones(build(d, kb, i) ^ o) + $countones(6'(i));
      if (c < bestCost) begin bestCost = c; best = i; end
    end
    return best;
  endfunction

  task automatic check(input string req, input logic [69:0] act, input logic [69:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] d, input logic [63:0] o, input logic [63:0] kb);
    newData = d; oldData = o; kernels = kb; inValid = 1'b1;
  endtask

  task automatic expectResult(input string req, input logic [63:0] d,
                              input logic [63:0] o, input logic [63:0] kb);
    int bi = bestIndex(d, o, kb);
    check({req, " valid"}, 70'(outValid), 70'(1));
    check({req, " word"},  {auxIndex, codeWord}, {6'(bi), build(d, kb, bi)});
    // R8: decoding with the reported index returns the data
    check({req, " R8 decode"}, 70'(build(codeWord, kb, int'(auxIndex))), 70'(d));
  endtask

  task automatic single(input string req, input logic [63:0] d,
                        input logic [63:0] o, input logic [63:0] kb);
    drive(d, o, kb);
    @(negedge clk); inValid = 1'b0;
    check({req, " R1 early"}, 70'(outValid), 70'(0));
    @(negedge clk);
    expectResult(req, d, o, kb);
    @(negedge clk);
    check({req, " R1 pulse"}, 70'(outValid), 70'(0));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 reset", {outValid, auxIndex, codeWord}, 71'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle", {outValid, auxIndex, codeWord}, 71'(0));

    // R5: every slice exactly 8 apart -> flags clear, kernel 0
    single("R5 half", 64'h0, {4{16'h00FF}}, 64'h0);
    check("R5 half flags", 70'(auxIndex), 70'(0));
    // R4: every slice fully apart -> all flags set, inverted output
    single("R4 invert", 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    check("R4 flags", 70'(auxIndex), 70'(6'h0F));
    check("R3 inverted word", 70'(codeWord), 70'(64'hFFFF_FFFF_FFFF_FFFF));
    // R7: identical kernels tie -> lowest number
    single("R7 tie", 64'h1234_5678_9ABC_DEF0, 64'h0F0F_3333_5555_AAAA, {4{16'hC3A5}});
    check("R7 kernel", 70'(auxIndex[5:4]), 70'(0));
    // R6: kernel 3 exactly matches old^data, others far
    single("R6 pick", 64'hA5A5_5A5A_0F0F_F0F0, 64'hA5A5_5A5A_0F0F_F0F0 ^ {4{16'h1357}},
           {16'h1357, 16'h6B2C, 16'h9D41, 16'h2E8F});
    // R3 directed: plain slices
    single("R3 plain", 64'h0001_0002_0004_0008, 64'h0, 64'h0);

    // R9: back-to-back strobes
    begin
      logic [63:0] d1 = {$urandom, $urandom}, o1 = {$urandom, $urandom}, k1 = {$urandom, $urandom};
      logic [63:0] d2 = {$urandom, $urandom}, o2 = {$urandom, $urandom}, k2 = {$urandom, $urandom};
      drive(d1, o1, k1);
      @(negedge clk); drive(d2, o2, k2);
      @(negedge clk); inValid = 1'b0;
      expectResult("R9 first", d1, o1, k1);
      @(negedge clk);
      expectResult("R9 second", d2, o2, k2);
      @(negedge clk);
      check("R9 end", 70'(outValid), 70'(0));
    end

    // R6 random: full search comparison
    for (int n = 0; n < 300; n++) begin
      logic [63:0] d = {$urandom, $urandom};
      logic [63:0] o = (n % 5 == 0) ? d : {$urandom, $urandom};
      logic [63:0] kb = {$urandom, $urandom};
      single("R6 random", d, o, kb);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule